// File: doc/BRIEF.md
# Dual-Clock FIFO with Credit-Count Exchange

This block moves data words from a producer clocked by `wclk_i` to a consumer clocked by `rclk_i`, where the two clocks have no fixed relation. Neither side looks at the other side's pointer. The write side keeps a count of free slots. The read side keeps a count of words it may take. Each count errs on the safe side, so the writer never sees more room than exists and the reader never sees more words than exist.

Each side gathers a local event count: words written on the write side, words removed on the read side. A toggle handshake carries that count across to the other domain. The handshake runs through synchroniser chains, and their length can be set by a parameter. A longer chain only delays the moment at which a full FIFO becomes not full, or an empty FIFO becomes not empty. A single multi-bit count crosses the boundary only while it is held steady, so a decode can never see a mix of bits from two different values.

The producer raises `w_valid_i`. A word is taken on a write clock edge only while `w_full_o` is low. The consumer raises `r_ready_i`. A word is removed on a read clock edge only while `r_empty_o` is low, and `r_data_o` shows the oldest word whenever `r_empty_o` is low.

Top module: `cfifo_top`

## Requirements
- R1: After both resets, `r_empty_o` is 1 and `w_full_o` is 0.
- R2: Words leave on `r_data_o` in the order they were accepted, with none lost and none repeated.
- R3: A write attempted while `w_full_o` is 1 is ignored. The stored contents and their order do not change.
- R4: A read attempted while `r_empty_o` is 1 is ignored. Later words still come out in order.
- R5: With no reads, `w_full_o` rises right after exactly DEPTH accepted writes and not before.
- R6: The read side is conservative. After the first write into an empty FIFO, `r_empty_o` is still 1 at the next read clock edge, and it falls within a bounded number of read cycles.
- R7: After one read from a full FIFO, `w_full_o` falls within a bounded number of write clock cycles.
- R8: Under concurrent write and read traffic at random rates on unrelated clocks, every word arrives in order, and a count is never changed while it is crossing between domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| w_rst_ni | input | 1 | Write-side reset, active low, asynchronous |
| w_valid_i | input | 1 | Write request |
| w_data_i | input | DW | Write data |
| w_full_o | output | 1 | No free slot visible to the writer |
| rclk_i | input | 1 | Read-side clock |
| r_rst_ni | input | 1 | Read-side reset, active low, asynchronous |
| r_ready_i | input | 1 | Read request |
| r_data_o | output | DW | Oldest stored word |
| r_empty_o | output | 1 | No word visible to the reader |

## Verification
A burst of writes with no reads tests how full is raised. It shows whether the flag rises at exactly DEPTH words, and whether an extra write is dropped or corrupts the stored words. Reads and writes applied to an empty FIFO test the lag on the read side and the handling of a read with nothing stored. Freeing a single slot in a full FIFO tests the return path of the count. Long runs of random traffic, with the writer's rate above and then below the reader's rate, keep both flags toggling. These runs reveal any lost, repeated or reordered word while counts are crossing in both directions at the same time.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/cfifo_mem.sv
module cfifo_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // a slot is read only after its count has crossed, so the word is stable
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cfifo_credit_xfer.sv
module cfifo_credit_xfer #(
  parameter int CW     = 4,
  parameter int STAGES = 2
) (
  input  logic          src_clk_i,
  input  logic          src_rst_ni,
  input  logic          src_inc_i,
  input  logic          dst_clk_i,
  input  logic          dst_rst_ni,
  output logic          dst_vld_o,
  output logic [CW-1:0] dst_cnt_o
);
  logic          req_q, ack_q;
  logic [CW-1:0] acc_q, hold_q, acc_nxt;
  logic [STAGES-1:0] ack_sync_q, req_sync_q;
  logic          busy;

  assign acc_nxt = acc_q + CW'(src_inc_i);
  assign busy    = req_q ^ ack_sync_q[STAGES-1];

  always_ff @(posedge src_clk_i or negedge src_rst_ni) begin
    if (!src_rst_ni) begin
      acc_q      <= '0;
      hold_q     <= '0;
      req_q      <= 1'b0;
      ack_sync_q <= '0;
    end else begin
      ack_sync_q <= {ack_sync_q[STAGES-2:0], ack_q};
      if (!busy && acc_nxt != '0) begin
        hold_q <= acc_nxt;
        acc_q  <= '0;
        req_q  <= ~req_q;
      end else begin
        acc_q <= acc_nxt;
      end
    end
  end

  always_ff @(posedge dst_clk_i or negedge dst_rst_ni) begin
    if (!dst_rst_ni) begin
      req_sync_q <= '0;
      ack_q      <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[STAGES-2:0], req_q};
      ack_q      <= req_sync_q[STAGES-1];
    end
  end

  assign dst_vld_o = req_sync_q[STAGES-1] ^ ack_q;
  assign dst_cnt_o = hold_q;

  p_hold_stable_r8: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    busy && $past(busy) |-> $stable(hold_q));
endmodule

// File: rtl/cfifo_top.sv
module cfifo_top #(
  parameter int DW           = 8,
  parameter int DEPTH        = 8,
  parameter int EXTRA_STAGES = 0,
  localparam int AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW          = $clog2(DEPTH + 1),
  localparam int STAGES      = 2 + EXTRA_STAGES
) (
  input  logic          wclk_i,
  input  logic          w_rst_ni,
  input  logic          w_valid_i,
  input  logic [DW-1:0] w_data_i,
  output logic          w_full_o,
  input  logic          rclk_i,
  input  logic          r_rst_ni,
  input  logic          r_ready_i,
  output logic [DW-1:0] r_data_o,
  output logic          r_empty_o
);
  import cfifo_pkg::*;

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] w_free_q, r_avail_q, pop_cnt, push_cnt;
  logic          push, pop, pop_vld, push_vld;

  assign push = w_valid_i && (w_free_q != '0);
  assign pop  = r_ready_i && (r_avail_q != '0);

  // write domain: free slots, returned by pops
  always_ff @(posedge wclk_i or negedge w_rst_ni) begin
    if (!w_rst_ni) begin
      wptr_q   <= '0;
      w_free_q <= CW'(DEPTH);
    end else begin
      if (push) wptr_q <= AW'(wrap_inc(32'(wptr_q), DEPTH));
      w_free_q <= w_free_q - CW'(push) + (pop_vld ? pop_cnt : '0);
    end
  end

  // read domain: words visible, granted by pushes
  always_ff @(posedge rclk_i or negedge r_rst_ni) begin
    if (!r_rst_ni) begin
      rptr_q    <= '0;
      r_avail_q <= '0;
    end else begin
      if (pop) rptr_q <= AW'(wrap_inc(32'(rptr_q), DEPTH));
      r_avail_q <= r_avail_q - CW'(pop) + (push_vld ? push_cnt : '0);
    end
  end

  assign w_full_o  = (w_free_q == '0);
  assign r_empty_o = (r_avail_q == '0);

  cfifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (push),
    .waddr_i(wptr_q),
    .wdata_i(w_data_i),
    .raddr_i(rptr_q),
    .rdata_o(r_data_o)
  );

  cfifo_credit_xfer #(.CW(CW), .STAGES(STAGES)) u_push_xfer (
    .src_clk_i (wclk_i),
    .src_rst_ni(w_rst_ni),
    .src_inc_i (push),
    .dst_clk_i (rclk_i),
    .dst_rst_ni(r_rst_ni),
    .dst_vld_o (push_vld),
    .dst_cnt_o (push_cnt)
  );

  cfifo_credit_xfer #(.CW(CW), .STAGES(STAGES)) u_pop_xfer (
    .src_clk_i (rclk_i),
    .src_rst_ni(r_rst_ni),
    .src_inc_i (pop),
    .dst_clk_i (wclk_i),
    .dst_rst_ni(w_rst_ni),
    .dst_vld_o (pop_vld),
    .dst_cnt_o (pop_cnt)
  );

  p_free_bound_r3: assert property (@(posedge wclk_i) disable iff (!w_rst_ni)
    w_free_q <= CW'(DEPTH));
  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!w_rst_ni)
    w_full_o && w_valid_i |=> $stable(wptr_q));
  p_no_underflow_r4: assert property (@(posedge rclk_i) disable iff (!r_rst_ni)
    r_empty_o && r_ready_i |=> $stable(rptr_q));
  p_avail_bound_r2: assert property (@(posedge rclk_i) disable iff (!r_rst_ni)
    r_avail_q <= CW'(DEPTH));
  p_full_by_push_r5: assert property (@(posedge wclk_i) disable iff (!w_rst_ni)
    $rose(w_full_o) |-> $past(push));
endmodule

// File: tb/cfifo_top_tb.sv
module cfifo_top_tb;
  localparam int  DW       = 8;
  localparam int  DEPTH    = 8;
  localparam time W_PERIOD = 10ns;
  localparam time R_PERIOD = 17ns;

  logic wclk = 0, rclk = 0, w_rst_n = 0, r_rst_n = 0;
  logic w_valid = 0, r_ready = 0, w_full, r_empty;
  logic [DW-1:0] w_data = '0, r_data;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] next_val = 8'h10;

  always #(W_PERIOD/2) wclk = ~wclk;
  always #(R_PERIOD/2) rclk = ~rclk;

  cfifo_top #(.DW(DW), .DEPTH(DEPTH), .EXTRA_STAGES(1)) u_dut (
    .wclk_i(wclk), .w_rst_ni(w_rst_n), .w_valid_i(w_valid), .w_data_i(w_data),
    .w_full_o(w_full), .rclk_i(rclk), .r_rst_ni(r_rst_n), .r_ready_i(r_ready),
    .r_data_o(r_data), .r_empty_o(r_empty));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write attempt; accepted iff full low at the edge
  task automatic wr_one(logic en);
    @(negedge wclk);
    w_valid = en;
    w_data  = next_val;
    if (en && !w_full) begin
      exp_q.push_back(next_val);
      next_val++;
    end
    @(posedge wclk);
    #1 w_valid = 0;
  endtask

  task automatic rd_one(string req, logic en);
    @(negedge rclk);
    r_ready = en;
    if (en && !r_empty) begin
      if (exp_q.size() == 0) check(req, 32'(r_data), 32'hDEAD);
      else check(req, 32'(r_data), 32'(exp_q.pop_front()));
    end
    @(posedge rclk);
    #1 r_ready = 0;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 200 && exp_q.size() > 0; i++) rd_one(req, 1'b1);
    check(req, 32'(exp_q.size()), 0);
  endtask

  task automatic t_reset;
    #1;
    check("R1 empty", 32'(r_empty), 1);
    check("R1 full", 32'(w_full), 0);
  endtask

  task automatic t_fill;  // R5, R3
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wclk);
      check("R5 not full early", 32'(w_full), 0);
      wr_one(1'b1);
    end
    @(negedge wclk);
    check("R5 full after DEPTH", 32'(w_full), 1);
    wr_one(1'b1);
    wr_one(1'b1);
    check("R3 extra write dropped", 32'(exp_q.size()), DEPTH);
    drain("R3 contents kept");
    repeat (20) @(negedge rclk);
    check("R3 empty after drain", 32'(r_empty), 1);
  endtask

  task automatic t_underflow;  // R4, R6
    rd_one("R4", 1'b1);
    rd_one("R4", 1'b1);
    wr_one(1'b1);
    @(posedge rclk); #1;
    check("R6 empty lags write", 32'(r_empty), 1);
    begin
      int k = 0;
      while (r_empty && k < 30) begin @(posedge rclk); #1; k++; end
      check("R6 empty clears", 32'(r_empty), 0);
    end
    drain("R4 order after empty read");
  endtask

  task automatic t_release;  // R7
    for (int i = 0; i < DEPTH; i++) wr_one(1'b1);
    repeat (20) @(negedge rclk);
    @(negedge wclk);
    check("R7 full before read", 32'(w_full), 1);
    rd_one("R7 data", 1'b1);
    begin
      int k = 0;
      while (w_full && k < 30) begin @(negedge wclk); k++; end
      check("R7 full clears", 32'(w_full), 0);
    end
    drain("R7 drain");
  endtask

  task automatic t_random(int wr_pct, int rd_pct, int n);  // R8, R2
    fork
      for (int i = 0; i < n; i++) wr_one(($urandom % 100) < wr_pct);
      for (int i = 0; i < n * 2; i++) rd_one("R8 random order", ($urandom % 100) < rd_pct);
    join
    drain("R2 final drain");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge rclk);
        w_rst_n = 1; r_rst_n = 1;
        t_reset();
        t_fill();
        t_underflow();
        t_release();
        t_random(90, 40, 400);
        t_random(30, 90, 400);
        t_random(70, 70, 600);
      end
      begin
        repeat (150000) @(posedge wclk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule